// File: doc/BRIEF.md
# Clusivity-Aware Cache Fill Handler

This block is a small direct-mapped cache slice that sits between an upper-level agent and the next memory level. It looks up each upstream request. On a miss it issues a line read downstream, and it places the returning fill either in the tag/data array or in a single one-line staging buffer. A static mode pin sets the relation to the cache above. The mostly-inclusive setting is the default and keeps every fill. The mostly-exclusive setting keeps a fill only when the request that caused it did not come from a caching agent, or when the request was a whole-line write, a prefetch, or a load-linked/store-conditional access.

A fill that is kept only in the staging buffer answers its request. After that answer it leaves through the eviction channel, as a writeback when it is dirty and as a clean-eviction notice when it is clean. One outgoing eviction register carries both these staged lines and the victims that array refills displace. While that register is held by back-pressure, no new downstream read starts and no fill is taken. In exclusive mode, a hit that hands the line upward with ownership gives the dirty state to the requester and drops the local copy.

Top module: `clus_fill_cache`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid, mem_req_valid and evict_valid are 0. Every line is invalid, so a first access to any address issues a downstream read.
- R2: With excl_mode=0 (mostly-inclusive), every miss fill is installed in the array. A repeat access to the same address then answers without a downstream read.
- R3: With excl_mode=1, a miss from a caching requester is not installed. This covers req_cmd 2 (shared read), 3 (read for ownership), and 0 (plain read) or 1 (plain write) with req_from_cache=1. A repeat access issues another downstream read.
- R4: With excl_mode=1, a fill is installed when the command is 0 or 1 with req_from_cache=0, or 5 (prefetch), 6 (load-linked), 7 (store-conditional) or 4 (whole-line write), whatever req_from_cache is.
- R5: A non-installed fill goes into the staging buffer, which is always empty at that point. Once answered, the buffer leaves on the eviction channel with evict_dirty=1 and the written data for a writing command (1, 4, 7). Otherwise it leaves with evict_dirty=0 and the fill data.
- R6: The eviction of a staged line is first presented (evict_valid rises) exactly one cycle after the cycle in which rsp_valid answers that request.
- R7: While evict_valid is 1 and evict_ready is 0, the eviction outputs hold steady, fill_ready stays 0 and no new downstream read is issued. Held evictions leave in the order they were created.
- R8: A hit with command 3 returns rsp_dirty equal to the line's dirty state and clears that state. With excl_mode=1 the line is also invalidated without any eviction. With excl_mode=0 it stays valid.
- R9: Staging and retiring a line in the buffer never disturbs the array. A non-installed fill whose index holds another valid line produces no victim eviction, and that line still hits afterwards.
- R10: An installing miss whose index holds a valid line of another tag first evicts that line, dirty state and data included. The downstream read for the new line is issued only after that eviction has been accepted.
- R11: A whole-line write (command 4) never issues a downstream read. It installs req_wdata as a dirty line and answers with that data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| excl_mode | input | 1 | 0 mostly-inclusive, 1 mostly-exclusive; static |
| req_valid | input | 1 | Upstream request valid |
| req_ready | output | 1 | Block can take a request |
| req_cmd | input | 3 | 0 plain read, 1 plain write, 2 shared read, 3 read for ownership, 4 whole-line write, 5 prefetch, 6 load-linked, 7 store-conditional |
| req_from_cache | input | 1 | Requester is a caching agent |
| req_addr | input | ADDR_W | Line address |
| req_wdata | input | DATA_W | Write data (one line) |
| rsp_valid | output | 1 | One-cycle upstream answer |
| rsp_data | output | DATA_W | Answer line data |
| rsp_dirty | output | 1 | Line handed up as modified |
| mem_req_valid | output | 1 | Downstream line read valid |
| mem_req_ready | input | 1 | Downstream takes the read |
| mem_req_addr | output | ADDR_W | Downstream read address |
| fill_valid | input | 1 | Fill data valid |
| fill_ready | output | 1 | Block accepts the fill |
| fill_data | input | DATA_W | Fill line data |
| evict_valid | output | 1 | Eviction valid |
| evict_ready | input | 1 | Eviction accepted |
| evict_addr | output | ADDR_W | Evicted line address |
| evict_data | output | DATA_W | Evicted line data |
| evict_dirty | output | 1 | 1 writeback, 0 clean-eviction notice |

## Verification
The collision that matters is a new fill or downstream read arriving while the eviction register still holds an earlier staged line. The bench provokes it by dropping evict_ready after an exclusive-mode staged read, then issuing a second non-installing miss at once. It then checks that no read leaves, that no answer appears and that fill_ready stays low, and after release that the two evictions come out in order. The second pairing is an answer and its own staged eviction. These are judged by cycle number, and the eviction must appear exactly one cycle after the answer.

// File: rtl/clus_fill_pkg.sv
package clus_fill_pkg;

   typedef enum logic [2:0] {
      CMD_RD_PLAIN  = 3'd0,
      CMD_WR_PLAIN  = 3'd1,
      CMD_RD_SHARED = 3'd2,
      CMD_RD_OWN    = 3'd3,
      CMD_WR_LINE   = 3'd4,
      CMD_PREFETCH  = 3'd5,
      CMD_LD_LINK   = 3'd6,
      CMD_ST_COND   = 3'd7
   } fill_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOKUP,
      ST_VICTIM,
      ST_FETCH,
      ST_FILL,
      ST_RESP
   } fill_state_e;

   function automatic logic cmd_writes(input logic [2:0] c);
      return (c == CMD_WR_PLAIN) || (c == CMD_WR_LINE) || (c == CMD_ST_COND);
   endfunction

endpackage

// File: rtl/clus_fill_policy.sv
module clus_fill_policy
   import clus_fill_pkg::*;
(
   input  logic       excl_mode,
   input  logic [2:0] cmd,
   input  logic       from_cache,
   output logic       alloc
);

   logic plain_op;
   logic always_keep;

   always_comb begin
      plain_op    = (cmd == CMD_RD_PLAIN) || (cmd == CMD_WR_PLAIN);
      always_keep = (cmd == CMD_WR_LINE) || (cmd == CMD_PREFETCH) ||
                    (cmd == CMD_LD_LINK) || (cmd == CMD_ST_COND);
      alloc       = !excl_mode || always_keep || (plain_op && !from_cache);
   end

endmodule

// File: rtl/clus_fill_array.sv
module clus_fill_array #(
   parameter int SETS   = 16,
   parameter int TAG_W  = 8,
   parameter int DATA_W = 32,
   localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  idx,
   output logic              rd_valid,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_dirty,
   input  logic              wr_en,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_dirty,
   input  logic              inv_en,
   input  logic              clr_dirty_en
);

   logic              v_all [SETS];
   logic              d_all [SETS];
   logic [TAG_W-1:0]  t_all [SETS];
   logic [DATA_W-1:0] x_all [SETS];

   for (genvar s = 0; s < SETS; s++) begin : g_set
      logic              v_r;
      logic              d_r;
      logic [TAG_W-1:0]  t_r;
      logic [DATA_W-1:0] x_r;
      logic              sel;

      assign sel = (idx == IDX_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_r <= 1'b0;
            d_r <= 1'b0;
            t_r <= '0;
            x_r <= '0;
         end else if (sel) begin
            if (wr_en) begin
               v_r <= 1'b1;
               d_r <= wr_dirty;
               t_r <= wr_tag;
               x_r <= wr_data;
            end else if (inv_en) begin
               v_r <= 1'b0;
               d_r <= 1'b0;
            end else if (clr_dirty_en) begin
               d_r <= 1'b0;
            end
         end
      end

      assign v_all[s] = v_r;
      assign d_all[s] = d_r;
      assign t_all[s] = t_r;
      assign x_all[s] = x_r;
   end

   assign rd_valid = v_all[idx];
   assign rd_dirty = d_all[idx];
   assign rd_tag   = t_all[idx];
   assign rd_data  = x_all[idx];

endmodule

// File: rtl/clus_fill_tmpbuf.sv
module clus_fill_tmpbuf #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [DATA_W-1:0] load_data,
   input  logic              load_dirty,
   input  logic              retire_en,
   input  logic              victim_en,
   input  logic [ADDR_W-1:0] victim_addr,
   input  logic [DATA_W-1:0] victim_data,
   input  logic              victim_dirty,
   output logic              tmp_valid,
   output logic              evict_valid,
   input  logic              evict_ready,
   output logic [ADDR_W-1:0] evict_addr,
   output logic [DATA_W-1:0] evict_data,
   output logic              evict_dirty,
   output logic              evict_is_tmp
);

   logic              tv_q;
   logic              td_q;
   logic [ADDR_W-1:0] ta_q;
   logic [DATA_W-1:0] tx_q;

   // staging line: invalidation touches only its valid bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tv_q <= 1'b0;
         td_q <= 1'b0;
         ta_q <= '0;
         tx_q <= '0;
      end else if (load_en) begin
         tv_q <= 1'b1;
         td_q <= load_dirty;
         ta_q <= load_addr;
         tx_q <= load_data;
      end else if (retire_en) begin
         tv_q <= 1'b0;
      end
   end

   // outgoing eviction register shared by staged lines and victims
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evict_valid  <= 1'b0;
         evict_addr   <= '0;
         evict_data   <= '0;
         evict_dirty  <= 1'b0;
         evict_is_tmp <= 1'b0;
      end else if (retire_en) begin
         evict_valid  <= 1'b1;
         evict_addr   <= ta_q;
         evict_data   <= tx_q;
         evict_dirty  <= td_q;
         evict_is_tmp <= 1'b1;
      end else if (victim_en) begin
         evict_valid  <= 1'b1;
         evict_addr   <= victim_addr;
         evict_data   <= victim_data;
         evict_dirty  <= victim_dirty;
         evict_is_tmp <= 1'b0;
      end else if (evict_valid && evict_ready) begin
         evict_valid  <= 1'b0;
      end
   end

   assign tmp_valid = tv_q;

endmodule

// File: rtl/clus_fill_ctrl.sv
module clus_fill_ctrl
   import clus_fill_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 4,
   localparam int TAG_W = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              excl_mode,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [2:0]        req_cmd,
   input  logic              req_from_cache,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_dirty,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              fill_valid,
   output logic              fill_ready,
   input  logic [DATA_W-1:0] fill_data,
   output logic [2:0]        cur_cmd,
   output logic              cur_from_cache,
   input  logic              alloc,
   output logic [IDX_W-1:0]  arr_idx,
   input  logic              arr_valid,
   input  logic [TAG_W-1:0]  arr_tag,
   input  logic [DATA_W-1:0] arr_data,
   input  logic              arr_dirty,
   output logic              arr_wr_en,
   output logic [TAG_W-1:0]  arr_wr_tag,
   output logic [DATA_W-1:0] arr_wr_data,
   output logic              arr_wr_dirty,
   output logic              arr_inv_en,
   output logic              arr_clr_en,
   output logic              tmp_load,
   output logic [DATA_W-1:0] tmp_line,
   output logic              tmp_line_dirty,
   output logic              tmp_retire,
   input  logic              tmp_valid,
   output logic              victim_en,
   output logic [ADDR_W-1:0] victim_addr,
   input  logic              ev_busy
);

   fill_state_e       state_q, state_d;
   logic [2:0]        cmd_q;
   logic              fc_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdat_q, rdat_d;
   logic              rdirty_q, rdirty_d;

   logic [TAG_W-1:0]  tag;
   logic              hit;
   logic              victim;
   logic              wr_cmd;
   logic              fill_fire;

   assign tag     = addr_q[ADDR_W-1:IDX_W];
   assign arr_idx = addr_q[IDX_W-1:0];
   assign hit     = arr_valid && (arr_tag == tag);
   assign victim  = arr_valid && !hit;
   assign wr_cmd  = cmd_writes(cmd_q);

   assign cur_cmd        = cmd_q;
   assign cur_from_cache = fc_q;
   assign victim_addr    = {arr_tag, arr_idx};
   assign mem_req_addr   = addr_q;

   assign req_ready     = (state_q == ST_IDLE);
   assign rsp_valid     = (state_q == ST_RESP);
   assign rsp_data      = rdat_q;
   assign rsp_dirty     = rdirty_q;
   assign mem_req_valid = (state_q == ST_FETCH) && !ev_busy;
   assign fill_ready    = (state_q == ST_FILL) && !ev_busy;
   assign fill_fire     = fill_valid && fill_ready;

   assign arr_wr_tag     = tag;
   assign tmp_line       = wr_cmd ? wdata_q : fill_data;
   assign tmp_line_dirty = wr_cmd;

   always_comb begin
      state_d      = state_q;
      rdat_d       = rdat_q;
      rdirty_d     = rdirty_q;
      arr_wr_en    = 1'b0;
      arr_wr_data  = wdata_q;
      arr_wr_dirty = 1'b1;
      arr_inv_en   = 1'b0;
      arr_clr_en   = 1'b0;
      tmp_load     = 1'b0;
      tmp_retire   = 1'b0;
      victim_en    = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req_valid) state_d = ST_LOOKUP;
         end
         ST_LOOKUP: begin
            rdirty_d = 1'b0;
            if (cmd_q == CMD_WR_LINE) begin
               if (victim) begin
                  state_d = ST_VICTIM;
               end else begin
                  arr_wr_en = 1'b1;
                  rdat_d    = wdata_q;
                  state_d   = ST_RESP;
               end
            end else if (hit) begin
               if (wr_cmd) begin
                  arr_wr_en = 1'b1;
                  rdat_d    = wdata_q;
               end else begin
                  rdat_d    = arr_data;
               end
               if (cmd_q == CMD_RD_OWN) begin
                  rdirty_d = arr_dirty;
                  if (excl_mode) arr_inv_en = 1'b1;
                  else           arr_clr_en = 1'b1;
               end
               state_d = ST_RESP;
            end else if (alloc && victim) begin
               state_d = ST_VICTIM;
            end else begin
               state_d = ST_FETCH;
            end
         end
         ST_VICTIM: begin
            if (!ev_busy) begin
               victim_en = 1'b1;
               if (cmd_q == CMD_WR_LINE) begin
                  arr_wr_en = 1'b1;
                  rdat_d    = wdata_q;
                  state_d   = ST_RESP;
               end else begin
                  arr_inv_en = 1'b1;
                  state_d    = ST_FETCH;
               end
            end
         end
         ST_FETCH: begin
            if (mem_req_valid && mem_req_ready) state_d = ST_FILL;
         end
         ST_FILL: begin
            if (fill_fire) begin
               if (alloc) begin
                  arr_wr_en    = 1'b1;
                  arr_wr_data  = tmp_line;
                  arr_wr_dirty = wr_cmd;
               end else begin
                  tmp_load = 1'b1;
               end
               rdat_d   = tmp_line;
               rdirty_d = 1'b0;
               state_d  = ST_RESP;
            end
         end
         ST_RESP: begin
            tmp_retire = tmp_valid;
            state_d    = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cmd_q    <= '0;
         fc_q     <= 1'b0;
         addr_q   <= '0;
         wdata_q  <= '0;
         rdat_q   <= '0;
         rdirty_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         rdat_q   <= rdat_d;
         rdirty_q <= rdirty_d;
         if (state_q == ST_IDLE && req_valid) begin
            cmd_q   <= req_cmd;
            fc_q    <= req_from_cache;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
      end
   end

endmodule

// File: rtl/clus_fill_cache.sv
module clus_fill_cache #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int SETS   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              excl_mode,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [2:0]        req_cmd,
   input  logic              req_from_cache,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_dirty,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              fill_valid,
   output logic              fill_ready,
   input  logic [DATA_W-1:0] fill_data,
   output logic              evict_valid,
   input  logic              evict_ready,
   output logic [ADDR_W-1:0] evict_addr,
   output logic [DATA_W-1:0] evict_data,
   output logic              evict_dirty
);

   localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
   localparam int TAG_W = ADDR_W - IDX_W;

   if ((1 << IDX_W) != SETS || SETS < 2) begin : g_bad_sets
      $error("SETS must be a power of two and at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the index width");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic [2:0]        cur_cmd;
   logic              cur_from_cache;
   logic              alloc;
   logic [IDX_W-1:0]  arr_idx;
   logic              arr_valid;
   logic [TAG_W-1:0]  arr_tag;
   logic [DATA_W-1:0] arr_data;
   logic              arr_dirty;
   logic              arr_wr_en;
   logic [TAG_W-1:0]  arr_wr_tag;
   logic [DATA_W-1:0] arr_wr_data;
   logic              arr_wr_dirty;
   logic              arr_inv_en;
   logic              arr_clr_en;
   logic              tmp_load;
   logic [DATA_W-1:0] tmp_line;
   logic              tmp_line_dirty;
   logic              tmp_retire;
   logic              tmp_valid;
   logic              victim_en;
   logic [ADDR_W-1:0] victim_addr;
   logic              evict_is_tmp;

   clus_fill_policy u_policy (
      .excl_mode  (excl_mode),
      .cmd        (cur_cmd),
      .from_cache (cur_from_cache),
      .alloc      (alloc)
   );

   clus_fill_array #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
      .clk          (clk),
      .rst_n        (rst_n),
      .idx          (arr_idx),
      .rd_valid     (arr_valid),
      .rd_tag       (arr_tag),
      .rd_data      (arr_data),
      .rd_dirty     (arr_dirty),
      .wr_en        (arr_wr_en),
      .wr_tag       (arr_wr_tag),
      .wr_data      (arr_wr_data),
      .wr_dirty     (arr_wr_dirty),
      .inv_en       (arr_inv_en),
      .clr_dirty_en (arr_clr_en)
   );

   clus_fill_tmpbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tmpbuf (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_en      (tmp_load),
      .load_addr    (mem_req_addr),
      .load_data    (tmp_line),
      .load_dirty   (tmp_line_dirty),
      .retire_en    (tmp_retire),
      .victim_en    (victim_en),
      .victim_addr  (victim_addr),
      .victim_data  (arr_data),
      .victim_dirty (arr_dirty),
      .tmp_valid    (tmp_valid),
      .evict_valid  (evict_valid),
      .evict_ready  (evict_ready),
      .evict_addr   (evict_addr),
      .evict_data   (evict_data),
      .evict_dirty  (evict_dirty),
      .evict_is_tmp (evict_is_tmp)
   );

   clus_fill_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .excl_mode      (excl_mode),
      .req_valid      (req_valid),
      .req_ready      (req_ready),
      .req_cmd        (req_cmd),
      .req_from_cache (req_from_cache),
      .req_addr       (req_addr),
      .req_wdata      (req_wdata),
      .rsp_valid      (rsp_valid),
      .rsp_data       (rsp_data),
      .rsp_dirty      (rsp_dirty),
      .mem_req_valid  (mem_req_valid),
      .mem_req_ready  (mem_req_ready),
      .mem_req_addr   (mem_req_addr),
      .fill_valid     (fill_valid),
      .fill_ready     (fill_ready),
      .fill_data      (fill_data),
      .cur_cmd        (cur_cmd),
      .cur_from_cache (cur_from_cache),
      .alloc          (alloc),
      .arr_idx        (arr_idx),
      .arr_valid      (arr_valid),
      .arr_tag        (arr_tag),
      .arr_data       (arr_data),
      .arr_dirty      (arr_dirty),
      .arr_wr_en      (arr_wr_en),
      .arr_wr_tag     (arr_wr_tag),
      .arr_wr_data    (arr_wr_data),
      .arr_wr_dirty   (arr_wr_dirty),
      .arr_inv_en     (arr_inv_en),
      .arr_clr_en     (arr_clr_en),
      .tmp_load       (tmp_load),
      .tmp_line       (tmp_line),
      .tmp_line_dirty (tmp_line_dirty),
      .tmp_retire     (tmp_retire),
      .tmp_valid      (tmp_valid),
      .victim_en      (victim_en),
      .victim_addr    (victim_addr),
      .ev_busy        (evict_valid)
   );

endmodule

// File: rtl/clus_fill_chk.sv
module clus_fill_chk #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rsp_valid,
   input logic              fill_ready,
   input logic              mem_req_valid,
   input logic              evict_valid,
   input logic              evict_ready,
   input logic [ADDR_W-1:0] evict_addr,
   input logic [DATA_W-1:0] evict_data,
   input logic              evict_dirty,
   input logic              evict_is_tmp,
   input logic              tmp_valid,
   input logic              tmp_load,
   input logic              tmp_retire
);

   // R6: a staged line appears on the eviction channel right after its answer
   a_r6_tmp_evict_follows_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(evict_valid) && evict_is_tmp) |-> $past(rsp_valid));

   // R7: a held eviction blocks fills and new downstream reads
   a_r7_fill_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (evict_valid && !evict_ready) |-> (!fill_ready && !mem_req_valid));

   // R7: a held eviction keeps its payload
   a_r7_evict_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (evict_valid && !evict_ready) |=> (evict_valid && $stable(evict_addr) &&
                                         $stable(evict_data) && $stable(evict_dirty)));

   // R5: the staging buffer is empty whenever a fill is placed in it
   a_r5_tmp_empty_on_load: assert property (@(posedge clk) disable iff (!rst_n)
      tmp_load |-> !tmp_valid);

   // R5: retiring the staging line empties it and raises the eviction
   a_r5_tmp_retired: assert property (@(posedge clk) disable iff (!rst_n)
      tmp_retire |=> (!tmp_valid && evict_valid && evict_is_tmp));

   // R2: an answer lasts a single cycle
   a_r2_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

bind clus_fill_cache clus_fill_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rsp_valid     (rsp_valid),
   .fill_ready    (fill_ready),
   .mem_req_valid (mem_req_valid),
   .evict_valid   (evict_valid),
   .evict_ready   (evict_ready),
   .evict_addr    (evict_addr),
   .evict_data    (evict_data),
   .evict_dirty   (evict_dirty),
   .evict_is_tmp  (evict_is_tmp),
   .tmp_valid     (tmp_valid),
   .tmp_load      (tmp_load),
   .tmp_retire    (tmp_retire)
);

// File: tb/clus_fill_cache_bench.sv
`timescale 1ns/1ps
module clus_fill_cache_bench;

   localparam int AW = 12;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          excl_mode = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [2:0]    req_cmd = '0;
   logic          req_from_cache = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_data;
   logic          rsp_dirty;
   logic          mem_req_valid;
   logic          mem_req_ready = 1'b1;
   logic [AW-1:0] mem_req_addr;
   logic          fill_valid = 1'b0;
   logic          fill_ready;
   logic [DW-1:0] fill_data = '0;
   logic          evict_valid;
   logic          evict_ready = 1'b1;
   logic [AW-1:0] evict_addr;
   logic [DW-1:0] evict_data;
   logic          evict_dirty;

   clus_fill_cache #(.ADDR_W(AW), .DATA_W(DW), .SETS(16)) u_clus_fill_cache (
      .clk(clk), .rst_n(rst_n), .excl_mode(excl_mode),
      .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
      .req_from_cache(req_from_cache), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_dirty(rsp_dirty),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .fill_valid(fill_valid), .fill_ready(fill_ready),
      .fill_data(fill_data), .evict_valid(evict_valid), .evict_ready(evict_ready),
      .evict_addr(evict_addr), .evict_data(evict_data), .evict_dirty(evict_dirty)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   int cyc    = 0;

   int          rsp_cnt = 0;
   int          rsp_cyc = 0;
   int          ev_cnt  = 0;
   int          ev_cyc  = 0;
   logic [AW-1:0] ev_addr_h [64];
   logic [DW-1:0] ev_data_h [64];
   logic          ev_dirty_h [64];
   int          mem_cnt = 0;
   int          mem_cyc = 0;

   logic [DW-1:0] got_data;
   logic          got_dirty;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rsp_valid) begin
         rsp_cnt <= rsp_cnt + 1;
         rsp_cyc <= cyc;
      end
      if (evict_valid && evict_ready) begin
         ev_addr_h[ev_cnt[5:0]]  <= evict_addr;
         ev_data_h[ev_cnt[5:0]]  <= evict_data;
         ev_dirty_h[ev_cnt[5:0]] <= evict_dirty;
         ev_cnt <= ev_cnt + 1;
         ev_cyc <= cyc;
      end
   end

   function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
      return 32'hF000_0000 | {20'h0, a};
   endfunction

   // downstream memory model
   initial begin
      forever begin
         @(negedge clk);
         if (mem_req_valid && mem_req_ready) begin
            mem_cnt = mem_cnt + 1;
            mem_cyc = cyc;
            fill_data = mem_val(mem_req_addr);
            repeat (2) @(negedge clk);
            fill_valid = 1'b1;
            while (!fill_ready) @(negedge clk);
            @(negedge clk);
            fill_valid = 1'b0;
         end
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic mode);
      @(negedge clk);
      rst_n = 1'b0;
      excl_mode = mode;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic do_req(input logic [2:0] c, input logic fc,
                         input logic [AW-1:0] a, input logic [DW-1:0] wd);
      int n;
      @(negedge clk);
      req_cmd = c; req_from_cache = fc; req_addr = a; req_wdata = wd;
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (!rsp_valid && n < 400) begin
         @(negedge clk);
         n++;
      end
      if (!rsp_valid) begin
         checks++; fails++;
         $display("FAIL answer timeout actual=0 expected=1");
      end
      got_data  = rsp_data;
      got_dirty = rsp_dirty;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 req_ready", {63'h0, req_ready}, 64'h1);
      chk("R1 rsp_valid", {63'h0, rsp_valid}, 64'h0);
      chk("R1 mem_req_valid", {63'h0, mem_req_valid}, 64'h0);
      chk("R1 evict_valid", {63'h0, evict_valid}, 64'h0);
   endtask

   task automatic t_incl_alloc;
      int m0;
      m0 = mem_cnt;
      do_req(3'd2, 1'b1, 12'h013, '0);
      chk("R1 first access misses", 64'(mem_cnt - m0), 64'd1);
      chk("R2 fill data", 64'(got_data), 64'(mem_val(12'h013)));
      m0 = mem_cnt;
      do_req(3'd2, 1'b1, 12'h013, '0);
      chk("R2 repeat hits", 64'(mem_cnt - m0), 64'd0);
      chk("R2 hit data", 64'(got_data), 64'(mem_val(12'h013)));
   endtask

   task automatic t_incl_own;
      int e0;
      do_req(3'd1, 1'b1, 12'h055, 32'hA5A5_0001);
      do_req(3'd3, 1'b1, 12'h055, '0);
      chk("R8 incl own hit dirty", {63'h0, got_dirty}, 64'h1);
      chk("R8 incl own data", 64'(got_data), 64'h0000_0000_A5A5_0001);
      do_req(3'd3, 1'b1, 12'h055, '0);
      chk("R8 incl kept, dirty cleared", {63'h0, got_dirty}, 64'h0);
      e0 = ev_cnt;
      do_req(3'd2, 1'b1, 12'h155, '0);
      chk("R10 victim count", 64'(ev_cnt - e0), 64'd1);
      chk("R10 victim addr", 64'(ev_addr_h[e0[5:0]]), 64'h055);
      chk("R8 victim clean after own", {63'h0, ev_dirty_h[e0[5:0]]}, 64'h0);
   endtask

   task automatic t_victim_order;
      int e0;
      do_req(3'd1, 1'b0, 12'h067, 32'h1234_5678);
      e0 = ev_cnt;
      do_req(3'd0, 1'b0, 12'h167, '0);
      chk("R10 dirty victim", {63'h0, ev_dirty_h[e0[5:0]]}, 64'h1);
      chk("R10 victim data", 64'(ev_data_h[e0[5:0]]), 64'h1234_5678);
      chk("R10 read after eviction", {63'h0, mem_cyc > ev_cyc}, 64'h1);
   endtask

   task automatic t_excl_bypass;
      int m0, e0;
      m0 = mem_cnt; e0 = ev_cnt;
      do_req(3'd2, 1'b1, 12'h013, '0);
      chk("R3 shared miss reads", 64'(mem_cnt - m0), 64'd1);
      chk("R5 staged clean evict", {63'h0, ev_dirty_h[e0[5:0]]}, 64'h0);
      chk("R5 staged evict data", 64'(ev_data_h[e0[5:0]]), 64'(mem_val(12'h013)));
      chk("R6 eviction one cycle after answer", 64'(ev_cyc - rsp_cyc), 64'd1);
      m0 = mem_cnt;
      do_req(3'd2, 1'b1, 12'h013, '0);
      chk("R3 shared not installed", 64'(mem_cnt - m0), 64'd1);
      do_req(3'd0, 1'b1, 12'h0A1, '0);
      m0 = mem_cnt;
      do_req(3'd0, 1'b1, 12'h0A1, '0);
      chk("R3 plain read from cache not installed", 64'(mem_cnt - m0), 64'd1);
   endtask

   task automatic t_excl_dirty_tmp;
      int e0;
      e0 = ev_cnt;
      do_req(3'd1, 1'b1, 12'h0B2, 32'hDEAD_0003);
      chk("R5 write answer data", 64'(got_data), 64'hDEAD_0003);
      chk("R5 staged writeback dirty", {63'h0, ev_dirty_h[e0[5:0]]}, 64'h1);
      chk("R5 staged writeback data", 64'(ev_data_h[e0[5:0]]), 64'hDEAD_0003);
      chk("R5 staged writeback addr", 64'(ev_addr_h[e0[5:0]]), 64'h0B2);
   endtask

   task automatic t_excl_alloc_kinds;
      logic [2:0] cl [5];
      logic       fl [5];
      int m0;
      cl[0] = 3'd0; fl[0] = 1'b0;
      cl[1] = 3'd1; fl[1] = 1'b0;
      cl[2] = 3'd5; fl[2] = 1'b1;
      cl[3] = 3'd6; fl[3] = 1'b1;
      cl[4] = 3'd7; fl[4] = 1'b1;
      for (int k = 0; k < 5; k++) begin
         logic [AW-1:0] a;
         logic [DW-1:0] w;
         a = 12'h0C8 + AW'(k);
         w = 32'h5000_0000 + DW'(k);
         do_req(cl[k], fl[k], a, w);
         m0 = mem_cnt;
         do_req(3'd2, 1'b1, a, '0);
         chk($sformatf("R4 installs cmd %0d", cl[k]), 64'(mem_cnt - m0), 64'd0);
         chk($sformatf("R4 data cmd %0d", cl[k]), 64'(got_data),
             64'((cl[k] == 3'd1 || cl[k] == 3'd7) ? w : mem_val(a)));
      end
   endtask

   task automatic t_write_line;
      int m0;
      m0 = mem_cnt;
      do_req(3'd4, 1'b1, 12'h0DE, 32'hC0DE_0004);
      chk("R11 no downstream read", 64'(mem_cnt - m0), 64'd0);
      chk("R11 answer data", 64'(got_data), 64'hC0DE_0004);
      do_req(3'd2, 1'b1, 12'h0DE, '0);
      chk("R11 installed", 64'(mem_cnt - m0), 64'd0);
      chk("R11 stored data", 64'(got_data), 64'hC0DE_0004);
   endtask

   task automatic t_excl_own_drop;
      int m0, e0;
      do_req(3'd1, 1'b0, 12'h0E5, 32'h0BAD_0005);
      m0 = mem_cnt; e0 = ev_cnt;
      do_req(3'd3, 1'b1, 12'h0E5, '0);
      chk("R8 own hit no read", 64'(mem_cnt - m0), 64'd0);
      chk("R8 own hit dirty", {63'h0, got_dirty}, 64'h1);
      chk("R8 own hit data", 64'(got_data), 64'h0BAD_0005);
      chk("R8 drop makes no eviction", 64'(ev_cnt - e0), 64'd0);
      do_req(3'd2, 1'b1, 12'h0E5, '0);
      chk("R8 dropped line misses", 64'(mem_cnt - m0), 64'd1);
   endtask

   task automatic t_tmp_separate;
      int m0, e0;
      do_req(3'd0, 1'b0, 12'h0F6, '0);
      e0 = ev_cnt;
      do_req(3'd2, 1'b1, 12'h1F6, '0);
      chk("R9 only staged eviction", 64'(ev_cnt - e0), 64'd1);
      chk("R9 staged eviction addr", 64'(ev_addr_h[e0[5:0]]), 64'h1F6);
      m0 = mem_cnt;
      do_req(3'd2, 1'b1, 12'h0F6, '0);
      chk("R9 array line still hits", 64'(mem_cnt - m0), 64'd0);
      chk("R9 array line data", 64'(got_data), 64'(mem_val(12'h0F6)));
   endtask

   task automatic t_stall;
      int e0, m0, r0;
      e0 = ev_cnt;
      evict_ready = 1'b0;
      do_req(3'd2, 1'b1, 12'h107, '0);
      m0 = mem_cnt; r0 = rsp_cnt;
      fork
         do_req(3'd2, 1'b1, 12'h108, '0);
         begin
            repeat (14) @(negedge clk);
            chk("R7 no read while held", 64'(mem_cnt - m0), 64'd0);
            chk("R7 no answer while held", 64'(rsp_cnt - r0), 64'd0);
            chk("R7 fill_ready low", {63'h0, fill_ready}, 64'h0);
            chk("R7 held addr", 64'(evict_addr), 64'h107);
            evict_ready = 1'b1;
         end
      join
      repeat (3) @(negedge clk);
      chk("R7 first out", 64'(ev_addr_h[e0[5:0]]), 64'h107);
      chk("R7 second out", 64'(ev_addr_h[(e0 + 1) % 64]), 64'h108);
      chk("R7 eviction count", 64'(ev_cnt - e0), 64'd2);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=expired expected=done");
      finish_run();
   end

   initial begin
      do_reset(1'b0);
      t_reset();
      t_incl_alloc();
      t_incl_own();
      t_victim_order();
      do_reset(1'b1);
      t_reset();
      t_excl_bypass();
      t_excl_dirty_tmp();
      t_excl_alloc_kinds();
      t_write_line();
      t_excl_own_drop();
      t_tmp_separate();
      t_stall();
      finish_run();
   end

endmodule